// File: doc/BRIEF.md
# Data-Space Address Generation Unit

This block forms the data-memory address for each load or store of a small 8-bit controller core and tells the memory system which region that address falls in. It contains the core's 32 working registers, 8 bits each. The top six of them pair up into three 16-bit pointers. A request selects one of five ways of forming the address: a full-width absolute address, a bare pointer, a pointer plus a short unsigned offset, a pointer that is stepped down before use, or a pointer that is stepped up after use. When a request steps a pointer, the new pointer value is written back into its register pair.

The address, the region selects and the error flags are registered and appear one clock after the request. The bottom of the data space is occupied by the working registers, then by peripheral I/O registers, then by internal SRAM. The working registers therefore also answer to data addresses. A write port takes a data address and, when that address lands in the register region, writes the matching register. A second write port and a combinational read port address the registers by number.

Top module: `dspace_agu`

## Requirements
- R1: A synchronous active-high reset clears all 32 registers to zero and drives every output to zero.
- R2: A legal request yields exactly one region select: registers for addresses 0–31, I/O for 32–95, SRAM for 96–159.
- R3: A legal request whose address is 160 or above raises `out_oor` and asserts no region select.
- R4: Mode 0 (absolute) uses `req_direct` unchanged as the address and modifies no register.
- R5: Mode 1 (pointer) uses the selected pointer value as the address and modifies no register. Pointer select 0 is the pair in registers 27:26, select 1 is 29:28, select 2 is 31:30, with the high byte in the odd register.
- R6: Mode 2 (pointer plus offset) adds the zero-extended 6-bit `req_disp` (0–63) to pointer 1 or 2, modulo 2^16, and modifies no register.
- R7: Mode 3 (step down) uses the pointer minus one as the address and writes it back. The borrow reaches the high byte, 0x0000 wraps to 0xFFFF, and the write-back happens even when the address is out of range.
- R8: Mode 4 (step up) uses the old pointer as the address and writes back the pointer plus one. The carry reaches the high byte, 0xFFFF wraps to 0x0000, and the write-back happens even when the address is out of range.
- R9: Modes 5–7, pointer select 3, and mode 2 with pointer select 0 are illegal. Such a request raises `out_illegal`, leaves `out_oor` and all region selects low, and modifies no register.
- R10: The outputs for a request appear on the clock edge that samples it. A cycle without `req_valid` yields all outputs zero one edge later.
- R11: `ds_we` with `ds_waddr` below 32 writes `ds_wdata` to the register of that number, which is then visible through `rf_rdata` and as a pointer. With an address of 32 or above the port changes no register.
- R12: On one edge, a pointer write-back overrides any other write to the same register, and a `rf_we` write overrides a `ds_we` write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Address request present |
| req_mode | input | 3 | Addressing mode (0 absolute, 1 pointer, 2 offset, 3 step down, 4 step up) |
| req_ptr | input | 2 | Pointer select (0, 1, 2) |
| req_disp | input | 6 | Unsigned offset for mode 2 |
| req_direct | input | 16 | Absolute address for mode 0 |
| rf_we | input | 1 | Register write by number |
| rf_widx | input | 5 | Register number to write |
| rf_wdata | input | 8 | Register write data |
| ds_we | input | 1 | Register write by data address |
| ds_waddr | input | 16 | Data address of the write |
| ds_wdata | input | 8 | Data-address write data |
| rf_ridx | input | 5 | Register number to read |
| rf_rdata | output | 8 | Combinational read data |
| out_valid | output | 1 | Registered result present |
| out_addr | output | 16 | Resolved data address |
| out_sel_rf | output | 1 | Address in register region |
| out_sel_io | output | 1 | Address in I/O region |
| out_sel_sram | output | 1 | Address in SRAM region |
| out_oor | output | 1 | Address beyond the decoded map |
| out_illegal | output | 1 | Illegal mode or pointer combination |

## Verification
The hardest cases to reach are the ones where a pointer write-back collides with another write to the same register on the same edge, and the step-up or step-down that carries or borrows across the byte boundary or wraps the full 16 bits. Random requests alone almost never produce a pointer that sits exactly at 0x00FF, 0x0000 or 0xFFFF while a second write aims at that pair. Directed steps therefore first load those pointer values through both write ports and then issue the modifying request together with a conflicting write. A random phase follows, in which pointer high bytes are mostly kept at zero so that all three regions and their edges are visited, and every register is read back after each step.

// File: rtl/agu_pkg.sv
package agu_pkg;

   typedef enum logic [2:0] {
      AM_ABS     = 3'd0,
      AM_PTR     = 3'd1,
      AM_OFFSET  = 3'd2,
      AM_STEPDN  = 3'd3,
      AM_STEPUP  = 3'd4
   } addr_mode_e;

   typedef struct packed {
      logic rf;
      logic io;
      logic sram;
   } region_t;

endpackage

// File: rtl/agu_regfile.sv
module agu_regfile #(
   parameter int DEPTH    = 32,
   parameter int DW       = 8,
   parameter int NPTR     = 3,
   parameter int PTR_BASE = 26,
   parameter int PSEL_W   = 2,
   localparam int IDX_W   = $clog2(DEPTH)
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic                          wr_en,
   input  logic [IDX_W-1:0]              wr_idx,
   input  logic [DW-1:0]                 wr_data,
   input  logic                          wb_en,
   input  logic [PSEL_W-1:0]             wb_ptr,
   input  logic [2*DW-1:0]               wb_val,
   input  logic [IDX_W-1:0]              rd_idx,
   output logic [DW-1:0]                 rd_data,
   output logic [NPTR-1:0][2*DW-1:0]     ptr_val
);

   logic [DW-1:0]    regs [DEPTH];
   logic [IDX_W-1:0] wb_lo;
   logic [IDX_W-1:0] wb_hi;

   assign wb_lo = IDX_W'(PTR_BASE + 2 * int'(wb_ptr));
   assign wb_hi = wb_lo + IDX_W'(1);

   // write-back assigned last, so it wins over wr_* on the same register
   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
      end else begin
         if (wr_en) regs[wr_idx] <= wr_data;
         if (wb_en) begin
            regs[wb_lo] <= wb_val[DW-1:0];
            regs[wb_hi] <= wb_val[2*DW-1:DW];
         end
      end
   end

   assign rd_data = regs[rd_idx];

   for (genvar p = 0; p < NPTR; p++) begin : g_ptr
      assign ptr_val[p] = {regs[PTR_BASE + 2*p + 1], regs[PTR_BASE + 2*p]};
   end

endmodule

// File: rtl/agu_addr_calc.sv
module agu_addr_calc
   import agu_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int DISP_W     = 6,
   parameter int NPTR       = 3,
   parameter int PSEL_W     = 2,
   parameter int DISP_FIRST = 1
) (
   input  logic [2:0]                    mode,
   input  logic [PSEL_W-1:0]             ptr_sel,
   input  logic [DISP_W-1:0]             disp,
   input  logic [ADDR_W-1:0]             direct,
   input  logic [NPTR-1:0][ADDR_W-1:0]   ptr_val,
   output logic [ADDR_W-1:0]             addr,
   output logic                          illegal,
   output logic                          wb_en,
   output logic [ADDR_W-1:0]             wb_val
);

   logic [ADDR_W-1:0] cur;
   logic              ptr_ok;
   addr_mode_e        m;

   always_comb begin
      cur    = '0;
      ptr_ok = 1'b0;
      for (int p = 0; p < NPTR; p++) begin
         if (int'(ptr_sel) == p) begin
            cur    = ptr_val[p];
            ptr_ok = 1'b1;
         end
      end
   end

   always_comb begin
      m       = addr_mode_e'(mode);
      addr    = '0;
      illegal = 1'b0;
      wb_en   = 1'b0;
      wb_val  = cur;
      case (m)
         AM_ABS: addr = direct;
         AM_PTR: begin
            addr    = cur;
            illegal = !ptr_ok;
         end
         AM_OFFSET: begin
            addr    = cur + ADDR_W'(disp);
            illegal = !ptr_ok || (int'(ptr_sel) < DISP_FIRST);
         end
         AM_STEPDN: begin
            wb_val  = cur - ADDR_W'(1);
            addr    = wb_val;
            illegal = !ptr_ok;
            wb_en   = ptr_ok;
         end
         AM_STEPUP: begin
            wb_val  = cur + ADDR_W'(1);
            addr    = cur;
            illegal = !ptr_ok;
            wb_en   = ptr_ok;
         end
         default: illegal = 1'b1;
      endcase
      if (illegal) addr = '0;
   end

endmodule

// File: rtl/agu_region_dec.sv
module agu_region_dec
   import agu_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int RF_SIZE   = 32,
   parameter int IO_SIZE   = 64,
   parameter int SRAM_SIZE = 64
) (
   input  logic [ADDR_W-1:0] addr,
   output region_t           region,
   output logic              oor
);

   localparam logic [ADDR_W-1:0] IO_LO   = ADDR_W'(RF_SIZE);
   localparam logic [ADDR_W-1:0] SRAM_LO = ADDR_W'(RF_SIZE + IO_SIZE);
   localparam logic [ADDR_W-1:0] MAP_END = ADDR_W'(RF_SIZE + IO_SIZE + SRAM_SIZE);

   assign region.rf = (addr < IO_LO);
   assign region.io = (addr >= IO_LO) && (addr < SRAM_LO);

   if (SRAM_SIZE == 0) begin : g_no_sram
      assign region.sram = 1'b0;
   end else begin : g_sram
      assign region.sram = (addr >= SRAM_LO) && (addr < MAP_END);
   end

   assign oor = (addr >= MAP_END);

endmodule

// File: rtl/dspace_agu.sv
module dspace_agu
   import agu_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DW        = 8,
   parameter int RF_DEPTH  = 32,
   parameter int IO_SIZE   = 64,
   parameter int SRAM_SIZE = 64,
   parameter int DISP_W    = 6,
   parameter int NPTR      = 3,
   parameter int PSEL_W    = 2,
   localparam int IDX_W    = $clog2(RF_DEPTH),
   localparam int PTR_BASE = RF_DEPTH - 2 * NPTR
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   input  logic [2:0]        req_mode,
   input  logic [PSEL_W-1:0] req_ptr,
   input  logic [DISP_W-1:0] req_disp,
   input  logic [ADDR_W-1:0] req_direct,
   input  logic              rf_we,
   input  logic [IDX_W-1:0]  rf_widx,
   input  logic [DW-1:0]     rf_wdata,
   input  logic              ds_we,
   input  logic [ADDR_W-1:0] ds_waddr,
   input  logic [DW-1:0]     ds_wdata,
   input  logic [IDX_W-1:0]  rf_ridx,
   output logic [DW-1:0]     rf_rdata,
   output logic              out_valid,
   output logic [ADDR_W-1:0] out_addr,
   output logic              out_sel_rf,
   output logic              out_sel_io,
   output logic              out_sel_sram,
   output logic              out_oor,
   output logic              out_illegal
);

   if (ADDR_W != 2 * DW) begin : g_bad_width
      $error("pointer pair width must equal the address width");
   end
   if (PTR_BASE < 0) begin : g_bad_ptr
      $error("register file too small for the pointer pairs");
   end
   if ((1 << PSEL_W) < NPTR) begin : g_bad_psel
      $error("pointer select too narrow");
   end
   if (RF_DEPTH + IO_SIZE + SRAM_SIZE >= (1 << ADDR_W)) begin : g_bad_map
      $error("decoded map exceeds the address space");
   end

   logic [NPTR-1:0][ADDR_W-1:0] ptr_val;
   logic [ADDR_W-1:0]           calc_addr;
   logic                        calc_illegal;
   logic                        calc_wb_en;
   logic [ADDR_W-1:0]           calc_wb_val;
   region_t                     region;
   logic                        region_oor;
   logic                        ds_in_rf;
   logic                        wr_en;
   logic [IDX_W-1:0]            wr_idx;
   logic [DW-1:0]               wr_data;

   assign ds_in_rf = ds_we && (ds_waddr < ADDR_W'(RF_DEPTH));
   assign wr_en    = rf_we || ds_in_rf;
   assign wr_idx   = rf_we ? rf_widx  : ds_waddr[IDX_W-1:0];
   assign wr_data  = rf_we ? rf_wdata : ds_wdata;

   agu_regfile #(
      .DEPTH(RF_DEPTH), .DW(DW), .NPTR(NPTR), .PTR_BASE(PTR_BASE), .PSEL_W(PSEL_W)
   ) u_rf (
      .clk(clk), .rst(rst),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .wb_en(req_valid && calc_wb_en), .wb_ptr(req_ptr), .wb_val(calc_wb_val),
      .rd_idx(rf_ridx), .rd_data(rf_rdata), .ptr_val(ptr_val)
   );

   agu_addr_calc #(
      .ADDR_W(ADDR_W), .DISP_W(DISP_W), .NPTR(NPTR), .PSEL_W(PSEL_W), .DISP_FIRST(1)
   ) u_calc (
      .mode(req_mode), .ptr_sel(req_ptr), .disp(req_disp), .direct(req_direct),
      .ptr_val(ptr_val), .addr(calc_addr), .illegal(calc_illegal),
      .wb_en(calc_wb_en), .wb_val(calc_wb_val)
   );

   agu_region_dec #(
      .ADDR_W(ADDR_W), .RF_SIZE(RF_DEPTH), .IO_SIZE(IO_SIZE), .SRAM_SIZE(SRAM_SIZE)
   ) u_dec (
      .addr(calc_addr), .region(region), .oor(region_oor)
   );

   always_ff @(posedge clk) begin
      if (rst || !req_valid) begin
         out_valid    <= 1'b0;
         out_addr     <= '0;
         out_sel_rf   <= 1'b0;
         out_sel_io   <= 1'b0;
         out_sel_sram <= 1'b0;
         out_oor      <= 1'b0;
         out_illegal  <= 1'b0;
      end else begin
         out_valid    <= 1'b1;
         out_addr     <= calc_addr;
         out_sel_rf   <= region.rf   && !calc_illegal;
         out_sel_io   <= region.io   && !calc_illegal;
         out_sel_sram <= region.sram && !calc_illegal;
         out_oor      <= region_oor  && !calc_illegal;
         out_illegal  <= calc_illegal;
      end
   end

endmodule

// File: rtl/agu_chk.sv
module agu_chk (
   input logic clk,
   input logic rst,
   input logic req_valid,
   input logic out_valid,
   input logic out_sel_rf,
   input logic out_sel_io,
   input logic out_sel_sram,
   input logic out_oor,
   input logic out_illegal
);

   AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
      $onehot0({out_sel_rf, out_sel_io, out_sel_sram}));  // R2

   AST_RESULT_UNIQUE: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> $countones({out_sel_rf, out_sel_io, out_sel_sram, out_oor, out_illegal}) == 1);  // R2

   AST_OOR_NOSEL: assert property (@(posedge clk) disable iff (rst)
      out_oor |-> !(out_sel_rf || out_sel_io || out_sel_sram));  // R3

   AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (rst)
      out_illegal |-> !(out_sel_rf || out_sel_io || out_sel_sram || out_oor));  // R9

   AST_REQ_LATENCY: assert property (@(posedge clk) disable iff (rst)
      req_valid |=> out_valid);  // R10

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> !(out_sel_rf || out_sel_io || out_sel_sram || out_oor || out_illegal));  // R10

endmodule

bind dspace_agu agu_chk u_chk (
   .clk(clk), .rst(rst), .req_valid(req_valid), .out_valid(out_valid),
   .out_sel_rf(out_sel_rf), .out_sel_io(out_sel_io), .out_sel_sram(out_sel_sram),
   .out_oor(out_oor), .out_illegal(out_illegal)
);

// File: tb/dspace_agu_tb_top.sv
`timescale 1ns/1ps
module dspace_agu_tb_top;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst;
   logic        req_valid;
   logic [2:0]  req_mode;
   logic [1:0]  req_ptr;
   logic [5:0]  req_disp;
   logic [15:0] req_direct;
   logic        rf_we;
   logic [4:0]  rf_widx;
   logic [7:0]  rf_wdata;
   logic        ds_we;
   logic [15:0] ds_waddr;
   logic [7:0]  ds_wdata;
   logic [4:0]  rf_ridx;
   logic [7:0]  rf_rdata;
   logic        out_valid;
   logic [15:0] out_addr;
   logic        out_sel_rf, out_sel_io, out_sel_sram, out_oor, out_illegal;

   int total = 0;
   int bad   = 0;
   bit done  = 0;
   logic [7:0] mdl [32];

   always #(CLK_PERIOD/2) clk = ~clk;

   dspace_agu dut_i (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode), .req_ptr(req_ptr),
      .req_disp(req_disp), .req_direct(req_direct), .rf_we(rf_we), .rf_widx(rf_widx),
      .rf_wdata(rf_wdata), .ds_we(ds_we), .ds_waddr(ds_waddr), .ds_wdata(ds_wdata),
      .rf_ridx(rf_ridx), .rf_rdata(rf_rdata), .out_valid(out_valid), .out_addr(out_addr),
      .out_sel_rf(out_sel_rf), .out_sel_io(out_sel_io), .out_sel_sram(out_sel_sram),
      .out_oor(out_oor), .out_illegal(out_illegal)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic logic [15:0] ptr_of(input int p);
      return {mdl[27 + 2*p], mdl[26 + 2*p]};
   endfunction

   // expected output bits {valid, rf, io, sram, oor, illegal}
   function automatic logic [5:0] exp_flags(input bit ill, input logic [15:0] a);
      if (ill)        return 6'b100001;
      if (a < 16'd32)  return 6'b110000;
      if (a < 16'd96)  return 6'b101000;
      if (a < 16'd160) return 6'b100100;
      return 6'b100010;
   endfunction

   task automatic idle_inputs();
      req_valid = 0; req_mode = 0; req_ptr = 0; req_disp = 0; req_direct = 0;
      rf_we = 0; rf_widx = 0; rf_wdata = 0; ds_we = 0; ds_waddr = 0; ds_wdata = 0;
   endtask

   task automatic check_regs(input string tag);
      for (int i = 0; i < 32; i++) begin
         rf_ridx = 5'(i);
         #1;
         chk(rf_rdata === mdl[i], tag, $sformatf("reg%0d", i), 32'(rf_rdata), 32'(mdl[i]));
      end
   endtask

   task automatic step(input bit vld, input int mode, input int ptr, input int disp,
                       input logic [15:0] dir, input bit rwe, input int ridx,
                       input logic [7:0] rdat, input bit dwe, input logic [15:0] daddr,
                       input logic [7:0] ddat, input string rtag);
      bit          ill;
      bit          wb;
      logic [15:0] a, nv, cur;
      logic [5:0]  ef, af;
      string       otag;
      @(negedge clk);
      req_valid = vld; req_mode = 3'(mode); req_ptr = 2'(ptr); req_disp = 6'(disp);
      req_direct = dir; rf_we = rwe; rf_widx = 5'(ridx); rf_wdata = rdat;
      ds_we = dwe; ds_waddr = daddr; ds_wdata = ddat;
      ill = (mode > 4) || ((mode != 0) && (ptr > 2)) || (mode == 2 && ptr == 0);
      cur = (ptr <= 2) ? ptr_of(ptr) : 16'h0;
      wb = 0; nv = cur; a = 16'h0;
      case (mode)
         0: begin a = dir; otag = "R4"; end
         1: begin a = cur; otag = "R5"; end
         2: begin a = cur + 16'(disp); otag = "R6"; end
         3: begin nv = cur - 16'd1; a = nv; wb = 1; otag = "R7"; end
         4: begin nv = cur + 16'd1; a = cur; wb = 1; otag = "R8"; end
         default: otag = "R9";
      endcase
      if (ill) begin otag = "R9"; wb = 0; a = 16'h0; end
      if (!vld) begin otag = "R10"; wb = 0; end
      @(posedge clk);
      #1;
      // register model update with R12 priority
      if (rwe) mdl[ridx] = rdat;
      else if (dwe && daddr < 16'd32) mdl[daddr[4:0]] = ddat;
      if (wb) begin
         mdl[26 + 2*ptr] = nv[7:0];
         mdl[27 + 2*ptr] = nv[15:8];
      end
      ef = vld ? exp_flags(ill, a) : 6'b000000;
      af = {out_valid, out_sel_rf, out_sel_io, out_sel_sram, out_oor, out_illegal};
      chk(af === ef, (vld && !ill) ? "R2/R3" : otag, $sformatf("flags %s", otag),
          32'(af), 32'(ef));
      chk(out_addr === (vld ? a : 16'h0), otag, "addr", 32'(out_addr), 32'(vld ? a : 16'h0));
      idle_inputs();
      check_regs(rtag);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int dummy;
      idle_inputs();
      rf_ridx = 0;
      dummy = $urandom(32'h5eed_0a61);
      rst = 1;
      for (int i = 0; i < 32; i++) mdl[i] = 8'h0;
      repeat (3) @(posedge clk);
      // R1: reset state while rst is still high
      #1;
      chk({out_valid, out_addr, out_sel_rf, out_sel_io, out_sel_sram, out_oor, out_illegal} === '0,
          "R1", "outputs after reset", 32'(out_addr), 32'h0);
      @(negedge clk); rst = 0;
      check_regs("R1");

      // R7: step down from 0x0000 wraps, out of range, still written back
      step(1, 3, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R7");
      // R8: step up from 0xFFFF wraps to 0x0000
      step(1, 4, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R8");
      // R8: carry across the byte boundary: Y = 0x00FF
      step(0, 0, 0, 0, 0, 1, 28, 8'hFF, 0, 0, 0, "R8");
      step(1, 4, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R8");
      // R7: borrow across the byte boundary: Y 0x0100 -> 0x00FF
      step(1, 3, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R7");
      // R11: load Z = 0x0060 through data-space writes, then use it
      step(0, 0, 0, 0, 0, 0, 0, 0, 1, 16'd30, 8'h60, "R11");
      step(1, 1, 2, 0, 0, 0, 0, 0, 0, 0, 0, "R5");
      step(1, 2, 2, 63, 0, 0, 0, 0, 0, 0, 0, "R6");
      step(1, 2, 2, 0, 0, 0, 0, 0, 0, 0, 0, "R6");
      // R11: data-space write above the register region changes nothing
      step(0, 0, 0, 0, 0, 0, 0, 0, 1, 16'd32, 8'hAA, "R11");
      step(0, 0, 0, 0, 0, 0, 0, 0, 1, 16'h801E, 8'hAA, "R11");
      // R9: offset with pointer 0, pointer select 3, modes 5..7
      step(1, 2, 0, 5, 0, 0, 0, 0, 0, 0, 0, "R9");
      step(1, 4, 3, 0, 0, 0, 0, 0, 0, 0, 0, "R9");
      for (int m = 5; m < 8; m++) step(1, m, 1, 0, 16'd40, 0, 0, 0, 0, 0, 0, "R9");
      // R2/R3/R4: absolute boundaries
      step(1, 0, 0, 0, 16'd31,  0, 0, 0, 0, 0, 0, "R4");
      step(1, 0, 0, 0, 16'd32,  0, 0, 0, 0, 0, 0, "R4");
      step(1, 0, 0, 0, 16'd95,  0, 0, 0, 0, 0, 0, "R4");
      step(1, 0, 0, 0, 16'd96,  0, 0, 0, 0, 0, 0, "R4");
      step(1, 0, 0, 0, 16'd159, 0, 0, 0, 0, 0, 0, "R3");
      step(1, 0, 0, 0, 16'd160, 0, 0, 0, 0, 0, 0, "R3");
      // R12: write-back beats a by-number write to the same register
      step(1, 4, 2, 0, 0, 1, 30, 8'h33, 0, 0, 0, "R12");
      // R12: write-back beats a data-space write to the same register
      step(1, 3, 2, 0, 0, 0, 0, 0, 1, 16'd31, 8'h77, "R12");
      // R12: by-number write beats data-space write
      step(0, 0, 0, 0, 0, 1, 5, 8'h12, 1, 16'd6, 8'h34, "R12");
      step(0, 0, 0, 0, 0, 1, 7, 8'h56, 1, 16'd7, 8'h78, "R12");
      // R10: idle cycle
      step(0, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R10");

      // random phase
      for (int n = 0; n < 600; n++) begin
         int          mode, ptr, ridx;
         logic [7:0]  rd, dd;
         logic [15:0] da, dir;
         bit          vld, rwe, dwe;
         vld  = ($urandom % 4) != 0;
         mode = ($urandom % 10 == 0) ? 5 + ($urandom % 3) : $urandom % 5;
         ptr  = ($urandom % 12 == 0) ? 3 : $urandom % 3;
         dir  = ($urandom % 3 == 0) ? 16'($urandom) : 16'($urandom % 200);
         rwe  = ($urandom % 3) == 0;
         ridx = ($urandom % 2) ? 26 + ($urandom % 6) : $urandom % 32;
         rd   = (ridx % 2 == 1 && ridx >= 26 && ($urandom % 4) != 0) ? 8'h0 : 8'($urandom);
         dwe  = ($urandom % 4) == 0;
         da   = ($urandom % 3 == 0) ? 16'($urandom) : 16'($urandom % 40);
         dd   = (da[0] && da >= 16'd26 && da < 16'd32) ? 8'($urandom % 2) : 8'($urandom);
         step(vld, mode, ptr, $urandom % 64, dir, rwe, ridx, rd, dwe, da, dd, "R11");
      end

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule